// File: doc/BRIEF.md
# Deadline-Based Response Release Unit

This unit sits beside a shared memory scheduler and hides, from each security domain, how much the other domains delay its memory traffic. Every accepted request is stamped with an expected issue time, used only to choose which waiting request the scheduler should take next, and an expected response time, which is the issue time plus the domain's current response delay. When the scheduler reports a completion, the response is not passed back at once. It is held and released on a precomputed cycle, so the latency a domain sees depends only on its own request stream.

A completion that arrives after its expected response time is a violation. Its release is rounded up to one of a few fixed late steps. If it is later than all of them, it falls back to the worst-case time of a static turn-based schedule. Each domain has a violation budget per period of completions. Once that budget is used, every remaining release of the period goes to the worst-case time. At the end of each period the domain's response delay is moved down or up by a step, based on the violations seen in that period, and kept within a clamp.

Each domain holds one request at a time. A per-domain slot walks through four states: `SL_IDLE` (empty), `SL_WAIT` (stamped, waiting for the scheduler), `SL_FLIGHT` (taken by the scheduler) and `SL_HOLD` (completed, waiting for its release cycle). The transitions are: accept (`SL_IDLE` to `SL_WAIT` on a request), issue (`SL_WAIT` to `SL_FLIGHT` when the scheduler takes this slot), complete (`SL_FLIGHT` to `SL_HOLD` on a completion) and release (`SL_HOLD` to `SL_IDLE` when the slot is released).

Top module: `deadline_release_unit`

## Requirements
- R1: Let `t` be the value of the free-running cycle counter at the accepting edge. The counter is 0 on the first edge after reset and then counts up by one per cycle. A request accepted at cycle `t` gets expected issue time `max(t, previous_ei + B_GAP)`. If the domain has never had a request since reset, the time is just `t`.
- R2: Among the domains in `SL_WAIT`, the output `win_dom` names the one with the smallest expected issue time. On a tie the lowest domain number wins. `win_ei` carries that time. When `issue_take` is high while `win_valid` is high, the winner moves to `SL_FLIGHT`.
- R3: The expected response time is the expected issue time plus the domain's delay at acceptance. The delay after reset is `D_INIT`. A completion at or before that time is released on exactly that cycle.
- R4: A late completion is released at `er + k*Q_STEP`, using the smallest `k` in 1..`Q_CNT-1` that is not before the completion cycle. If no such `k` exists, it is released at the worst-case time instead.
- R5: A late completion counts as a violation only while the domain has fewer than `VIOL_MAX` violations in the current period. Once `VIOL_MAX` is reached, every completion of the domain is released at the worst-case time until the period ends.
- R6: The worst-case time of request `i` of domain `s` is `s*T_TURN + i*T_TURN*N_DOM + T_TURN`. Here `i` counts the domain's accepted requests from 0 since reset. If that time has already passed, the release happens on the completion cycle itself.
- R7: A period is `PERIOD` completions of one domain. The completion that ends a period clears that domain's violation count and leaves worst-case mode.
- R8: At a period end, let `v` be the violations in that period, including the one from the ending completion. If `v <= TH_LO`, the delay drops by `D_STEP`. Otherwise, if `v >= TH_HI`, it rises by `D_STEP`. Otherwise it is unchanged.
- R9: The delay never leaves the range `D_MIN`..`D_MAX`. A step that would cross a bound stops at that bound.
- R10: At most one release occurs per cycle. A slot is due when its release time is at or before the current cycle. Among the due slots, the one with the smallest release time is released first; on a tie the lowest domain number goes first.
- R11: A request is ignored for a domain that is not `SL_IDLE`. A completion is ignored for a domain that is not `SL_FLIGHT`. Neither changes any later output.
- R12: After reset, `win_valid` and `rel_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request arrives this cycle |
| req_dom | input | DOM_W | Domain number of the new request |
| issue_take | input | 1 | Scheduler takes the current winner |
| cpl_valid | input | 1 | A request finishes this cycle |
| cpl_dom | input | DOM_W | Domain number of the finished request |
| win_valid | output | 1 | Some domain is waiting for issue |
| win_dom | output | DOM_W | Arbitration winner |
| win_ei | output | TIME_W | Expected issue time of the winner |
| rel_valid | output | 1 | A response is released this cycle |
| rel_dom | output | DOM_W | Domain whose response is released |

## Verification
A corrupted per-domain delay or violation count does not show at once. It shows when that domain's next response leaves on a wrong cycle, which can be up to one whole request latency later. A wrong expected issue time shows on `win_ei` in the first cycle that slot waits. A stale period counter stays hidden until the next period boundary. Only then do the tuned delay or the worst-case mode turn up as shifted release cycles. For this reason the bench compares both the winner and the release strobe on every cycle, against a model that tracks the delay, the budget and the period of each domain.

// File: rtl/drr_pkg.sv
package drr_pkg;
    typedef enum logic [1:0] {
        SL_IDLE   = 2'd0,
        SL_WAIT   = 2'd1,
        SL_FLIGHT = 2'd2,
        SL_HOLD   = 2'd3
    } slot_state_e;
endpackage

// File: rtl/drr_pick.sv
module drr_pick #(
    parameter int N  = 2,
    parameter int KW = 32,
    parameter int IW = 1
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][KW-1:0] key,
    output logic                 any,
    output logic [IW-1:0]        idx
);
    logic [KW-1:0] best;

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!any || key[i] < best)) begin
                any  = 1'b1;
                best = key[i];
                idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/drr_slot.sv
module drr_slot
    import drr_pkg::*;
#(
    parameter int TIME_W   = 32,
    parameter int SLOT_ID  = 0,
    parameter int N_DOM    = 2,
    parameter int B_GAP    = 6,
    parameter int D_INIT   = 160,
    parameter int D_MIN    = 16,
    parameter int D_MAX    = 320,
    parameter int D_STEP   = 8,
    parameter int Q_STEP   = 32,
    parameter int Q_CNT    = 4,
    parameter int VIOL_MAX = 4,
    parameter int PERIOD   = 1000,
    parameter int TH_LO    = 0,
    parameter int TH_HI    = 3,
    parameter int T_TURN   = 43
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              req_hit,
    input  logic              take_hit,
    input  logic              cpl_hit,
    input  logic              rel_hit,
    output logic              wait_v,
    output logic [TIME_W-1:0] ei_o,
    output logic              hold_v,
    output logic [TIME_W-1:0] rel_t_o
);
    localparam int CW = $clog2(VIOL_MAX + 2);
    localparam int PW = $clog2(PERIOD + 1);
    localparam logic [TIME_W-1:0] B_T    = TIME_W'(B_GAP);
    localparam logic [TIME_W-1:0] DINI_T = TIME_W'(D_INIT);
    localparam logic [TIME_W-1:0] DMIN_T = TIME_W'(D_MIN);
    localparam logic [TIME_W-1:0] DMAX_T = TIME_W'(D_MAX);
    localparam logic [TIME_W-1:0] DSTP_T = TIME_W'(D_STEP);
    localparam logic [TIME_W-1:0] WBASE  = TIME_W'(SLOT_ID * T_TURN + T_TURN);
    localparam logic [TIME_W-1:0] WROUND = TIME_W'(T_TURN * N_DOM);
    localparam logic [CW-1:0]     VMAX_C = CW'(VIOL_MAX);
    localparam logic [CW-1:0]     TLO_C  = CW'(TH_LO);
    localparam logic [CW-1:0]     THI_C  = CW'(TH_HI);
    localparam logic [PW-1:0]     PLAST  = PW'(PERIOD - 1);

    slot_state_e state_q, state_d;

    logic [TIME_W-1:0] ei_q, er_q, rel_q, worst_q, last_q, d_q, idx_q;
    logic              have_q;
    logic [CW-1:0]     viol_q;
    logic [PW-1:0]     per_q;

    logic [TIME_W-1:0] ei_cand, ei_new, worst_rel, rel_calc, d_tuned;
    logic              late, exhausted, viol_inc, per_end;
    logic [CW-1:0]     v_tot;

    // expected issue time of an arriving request
    assign ei_cand = last_q + B_T;
    assign ei_new  = (have_q && ei_cand > now) ? ei_cand : now;

    // release time of a completion arriving now
    assign worst_rel = (worst_q > now) ? worst_q : now;
    assign late      = now > er_q;
    assign exhausted = viol_q >= VMAX_C;
    assign viol_inc  = late && !exhausted;
    assign per_end   = per_q == PLAST;
    assign v_tot     = viol_q + (viol_inc ? CW'(1) : CW'(0));

    always_comb begin
        rel_calc = er_q;
        if (exhausted) begin
            rel_calc = worst_rel;
        end else if (late) begin
            rel_calc = worst_rel;
            for (int k = Q_CNT - 2; k >= 0; k--) begin
                if (er_q + TIME_W'((k + 1) * Q_STEP) >= now)
                    rel_calc = er_q + TIME_W'((k + 1) * Q_STEP);
            end
        end
    end

    // delay tuning at a period end, clamped
    always_comb begin
        d_tuned = d_q;
        if (v_tot <= TLO_C)
            d_tuned = (d_q >= DMIN_T + DSTP_T) ? d_q - DSTP_T : DMIN_T;
        else if (v_tot >= THI_C)
            d_tuned = (d_q + DSTP_T <= DMAX_T) ? d_q + DSTP_T : DMAX_T;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SL_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept, issue, complete, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_IDLE:   if (req_hit)  state_d = SL_WAIT;
            SL_WAIT:   if (take_hit) state_d = SL_FLIGHT;
            SL_FLIGHT: if (cpl_hit)  state_d = SL_HOLD;
            SL_HOLD:   if (rel_hit)  state_d = SL_IDLE;
        endcase
    end

    // timing and budget registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ei_q    <= '0;
            er_q    <= '0;
            rel_q   <= '0;
            worst_q <= '0;
            last_q  <= '0;
            idx_q   <= '0;
            have_q  <= 1'b0;
            d_q     <= DINI_T;
            viol_q  <= '0;
            per_q   <= '0;
        end else begin
            unique case (state_q)
                SL_IDLE: if (req_hit) begin
                    ei_q    <= ei_new;
                    er_q    <= ei_new + d_q;
                    worst_q <= WBASE + idx_q * WROUND;
                    idx_q   <= idx_q + 1'b1;
                    last_q  <= ei_new;
                    have_q  <= 1'b1;
                end
                SL_FLIGHT: if (cpl_hit) begin
                    rel_q <= rel_calc;
                    if (per_end) begin
                        per_q  <= '0;
                        viol_q <= '0;
                        d_q    <= d_tuned;
                    end else begin
                        per_q  <= per_q + 1'b1;
                        viol_q <= v_tot;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wait_v  = state_q == SL_WAIT;
        hold_v  = state_q == SL_HOLD;
        ei_o    = ei_q;
        rel_t_o = rel_q;
    end

    // R9
    d_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_q >= DMIN_T || d_q == DINI_T);
    // R9
    d_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_q <= DMAX_T || d_q == DINI_T);
    // R5
    viol_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q <= VMAX_C);
    // R3
    no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_hit |-> (state_q == SL_HOLD && now >= rel_q));
    // R1
    ei_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_IDLE && req_hit && have_q) |=> ei_q >= $past(last_q) + B_T);
    // R7
    period_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_FLIGHT && cpl_hit && per_end) |=> viol_q == '0);
endmodule

// File: rtl/deadline_release_unit.sv
module deadline_release_unit #(
    parameter int TIME_W   = 32,
    parameter int N_DOM    = 2,
    parameter int B_GAP    = 6,
    parameter int D_INIT   = 160,
    parameter int D_MIN    = 16,
    parameter int D_MAX    = 320,
    parameter int D_STEP   = 8,
    parameter int Q_STEP   = 32,
    parameter int Q_CNT    = 4,
    parameter int VIOL_MAX = 4,
    parameter int PERIOD   = 1000,
    parameter int TH_LO    = 0,
    parameter int TH_HI    = 3,
    parameter int T_TURN   = 43,
    localparam int DOM_W   = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DOM_W-1:0]  req_dom,
    input  logic              issue_take,
    input  logic              cpl_valid,
    input  logic [DOM_W-1:0]  cpl_dom,
    output logic              win_valid,
    output logic [DOM_W-1:0]  win_dom,
    output logic [TIME_W-1:0] win_ei,
    output logic              rel_valid,
    output logic [DOM_W-1:0]  rel_dom
);
    logic [TIME_W-1:0] now_q;
    logic [N_DOM-1:0]             wait_v, hold_v, due_v;
    logic [N_DOM-1:0][TIME_W-1:0] ei_v, rel_t;

    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    for (genvar s = 0; s < N_DOM; s++) begin : g_slot
        drr_slot #(
            .TIME_W(TIME_W), .SLOT_ID(s), .N_DOM(N_DOM), .B_GAP(B_GAP),
            .D_INIT(D_INIT), .D_MIN(D_MIN), .D_MAX(D_MAX), .D_STEP(D_STEP),
            .Q_STEP(Q_STEP), .Q_CNT(Q_CNT), .VIOL_MAX(VIOL_MAX),
            .PERIOD(PERIOD), .TH_LO(TH_LO), .TH_HI(TH_HI), .T_TURN(T_TURN)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .now     (now_q),
            .req_hit (req_valid && req_dom == DOM_W'(s)),
            .take_hit(issue_take && win_valid && win_dom == DOM_W'(s)),
            .cpl_hit (cpl_valid && cpl_dom == DOM_W'(s)),
            .rel_hit (rel_valid && rel_dom == DOM_W'(s)),
            .wait_v  (wait_v[s]),
            .ei_o    (ei_v[s]),
            .hold_v  (hold_v[s]),
            .rel_t_o (rel_t[s])
        );
        assign due_v[s] = hold_v[s] && rel_t[s] <= now_q;
    end

    drr_pick #(.N(N_DOM), .KW(TIME_W), .IW(DOM_W)) u_win (
        .cand(wait_v), .key(ei_v), .any(win_valid), .idx(win_dom)
    );

    drr_pick #(.N(N_DOM), .KW(TIME_W), .IW(DOM_W)) u_rel (
        .cand(due_v), .key(rel_t), .any(rel_valid), .idx(rel_dom)
    );

    assign win_ei = ei_v[win_dom];

    // R2
    win_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> wait_v[win_dom]);
    // R10
    rel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> (hold_v[rel_dom] && $countones(due_v) >= 1));
    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!win_valid && !rel_valid));
endmodule

// File: tb/deadline_release_unit_test.sv
`timescale 1ns/1ps
module deadline_release_unit_test;
    localparam int ND = 2, BG = 6, DI = 20, DMN = 8, DMX = 32, DS = 4;
    localparam int QS = 8, QC = 3, VM = 2, PER = 4, TLO = 0, THI = 2, TT = 43;
    localparam int NCYC = 2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, issue_take = 1'b0, cpl_valid = 1'b0;
    logic [0:0] req_dom = '0, cpl_dom = '0;
    logic win_valid, rel_valid;
    logic [0:0] win_dom, rel_dom;
    logic [31:0] win_ei;

    always #2.5 clk = ~clk;

    deadline_release_unit #(
        .TIME_W(32), .N_DOM(ND), .B_GAP(BG), .D_INIT(DI), .D_MIN(DMN),
        .D_MAX(DMX), .D_STEP(DS), .Q_STEP(QS), .Q_CNT(QC), .VIOL_MAX(VM),
        .PERIOD(PER), .TH_LO(TLO), .TH_HI(THI), .T_TURN(TT)
    ) uut (.*);

    int tests = 0, fails = 0;
    bit done = 0;
    int m_st[ND], m_ei[ND], m_er[ND], m_rel[ND], m_wst[ND], m_last[ND];
    int m_have[ND], m_d[ND], m_viol[ND], m_per[ND], m_idx[ND], m_kind[ND], m_iss[ND];
    int m_now;
    int lat[ND];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, m_now);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ew; int ewd; bit er_v; int erd;
        bit gen, take_en, spam, stray;
        for (int d = 0; d < ND; d++) begin
            m_st[d] = 0; m_have[d] = 0; m_d[d] = DI; m_viol[d] = 0;
            m_per[d] = 0; m_idx[d] = 0; m_last[d] = 0;
        end
        m_now = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: quiet after reset
        check(win_valid == 1'b0, "R12 win_valid", int'(win_valid), 0);
        check(rel_valid == 1'b0, "R12 rel_valid", int'(rel_valid), 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            if (cyc != 0) @(negedge clk);
            // expected outputs from model state
            ew = 0; ewd = 0; er_v = 0; erd = 0;
            for (int d = 0; d < ND; d++) begin
                if (m_st[d] == 1 && (!ew || m_ei[d] < m_ei[ewd])) begin ew = 1; ewd = d; end
                if (m_st[d] == 3 && m_rel[d] <= m_now && (!er_v || m_rel[d] < m_rel[erd])) begin
                    er_v = 1; erd = d;
                end
            end
            // R2 winner, R1 its issue time
            check(win_valid == ew && (!ew || int'(win_dom) == ewd), "R2 winner",
                  win_valid ? int'(win_dom) : -1, ew ? ewd : -1);
            if (ew) check(int'(win_ei) == m_ei[ewd], "R1 win_ei", int'(win_ei), m_ei[ewd]);
            // release: R3 R8 R9 on time, R4 quantized, R5 R6 R7 worst; R10 R11 order/ignore
            if (er_v)
                check(rel_valid && int'(rel_dom) == erd,
                      m_kind[erd] == 0 ? "R3 R8 R9 R10 release" :
                      m_kind[erd] == 1 ? "R4 R7 R10 release" : "R5 R6 R7 R10 release",
                      rel_valid ? int'(rel_dom) : -1, erd);
            else
                check(!rel_valid, "R10 R11 no release", rel_valid ? int'(rel_dom) : -1, -1);

            // scenario
            gen = 1; take_en = 1; spam = 0; stray = 0;
            if (cyc < 400) begin lat[0] = 5; lat[1] = 9; end
            else if (cyc < 800) begin lat[0] = 30; lat[1] = 40; take_en = (cyc >= 430); end
            else if (cyc < 1200) begin lat[0] = 120; lat[1] = 3; end
            else if (cyc < 1500) begin lat[0] = 12; lat[1] = 25; spam = 1; stray = 1; end
            else begin lat[0] = 2; lat[1] = 2; end

            req_valid = 0; req_dom = '0;
            if (spam) begin req_valid = 1; req_dom = 1'(cyc % 2); end
            else if (gen) begin
                for (int j = 0; j < ND; j++) begin
                    int d; d = (j + cyc) % ND;
                    if (!req_valid && m_st[d] == 0) begin req_valid = 1; req_dom = 1'(d); end
                end
            end
            issue_take = take_en && ew;
            cpl_valid = 0; cpl_dom = '0;
            for (int d = 0; d < ND; d++)
                if (!cpl_valid && m_st[d] == 2 && m_now - m_iss[d] >= lat[d]) begin
                    cpl_valid = 1; cpl_dom = 1'(d);
                end
            if (!cpl_valid && stray && m_st[cyc % 2] != 2) begin
                cpl_valid = 1; cpl_dom = 1'(cyc % 2);   // R11 stray completion
            end

            // model update for the coming edge
            if (req_valid && m_st[req_dom] == 0) begin
                int d; d = int'(req_dom);
                m_ei[d] = (m_have[d] && m_last[d] + BG > m_now) ? m_last[d] + BG : m_now;
                m_er[d] = m_ei[d] + m_d[d];
                m_wst[d] = d * TT + m_idx[d] * TT * ND + TT;
                m_idx[d]++; m_last[d] = m_ei[d]; m_have[d] = 1; m_st[d] = 1;
            end
            if (cpl_valid && m_st[cpl_dom] == 2) begin
                int d, t, wr; bit lt, ex;
                d = int'(cpl_dom); t = m_now;
                lt = t > m_er[d]; ex = m_viol[d] >= VM;
                wr = (m_wst[d] > t) ? m_wst[d] : t;
                if (ex) begin m_rel[d] = wr; m_kind[d] = 2; end
                else if (!lt) begin m_rel[d] = m_er[d]; m_kind[d] = 0; end
                else begin
                    m_rel[d] = wr; m_kind[d] = 2;
                    for (int k = 1; k < QC; k++)
                        if (m_kind[d] == 2 && m_er[d] + k * QS >= t) begin
                            m_rel[d] = m_er[d] + k * QS; m_kind[d] = 1;
                        end
                end
                if (lt && !ex) m_viol[d]++;
                if (m_per[d] == PER - 1) begin
                    if (m_viol[d] <= TLO) m_d[d] = (m_d[d] - DS < DMN) ? DMN : m_d[d] - DS;
                    else if (m_viol[d] >= THI) m_d[d] = (m_d[d] + DS > DMX) ? DMX : m_d[d] + DS;
                    m_viol[d] = 0; m_per[d] = 0;
                end else m_per[d]++;
                m_st[d] = 3;
            end
            if (issue_take && ew) begin m_st[ewd] = 2; m_iss[ewd] = m_now; end
            if (er_v) m_st[erd] = 0;
            m_now++;
        end
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule